// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block is the slave side of a small serial memory that is reached over chip select, a serial clock, a data input and a data output. The serial clock is the block clock. While chip select is high, each rising clock edge samples one input bit. A command is a start bit of one, a two-bit opcode, an address, and then a data word when the opcode is a write. The word size is 8 or 16 bits, and an organization pin picks it. The storage is an array of byte registers that reset clears.

A read puts one zero bit on the output first. It then streams the addressed word MSB first. After that it carries on with the words at the next addresses, wrapping from the top of memory back to zero, until chip select drops. Outside a read the output enable is low, and the data pin then reads as zero.

The decoder has six states. IDLE waits for a one. On a one it moves to OPCODE. OPCODE takes two bits and moves to ADDRESS. At the last address bit, ADDRESS moves to READ-STREAM on opcode 10, to WRITE-DATA on opcode 01, and to DISCARD on any other opcode. WRITE-DATA takes one word and moves to DISCARD. READ-STREAM stays in place and advances the address after every word. DISCARD ignores all further bits. Any edge that samples chip select low sends every state back to IDLE.

Top module: `tw_mem_slave`

## Requirements
- R1: After reset, dout_oe and dout are 0 and every stored byte reads back as zero.
- R2: While in IDLE, zeros sampled with chip select high are ignored. The first one sampled is the start bit.
- R3: After the start bit come two opcode bits and then the address, both MSB first. The address is ABITS_W16 bits (default 6) when org=1, which selects 16-bit words. It is ABITS_W16+1 bits when org=0, which selects 8-bit words.
- R4: Opcode 01 is a write. It is followed by one data word, MSB first. The word is stored on the edge that samples its last bit, and later bits are ignored until chip select drops. With org=1, 16-bit word a is bytes 2a (high half) and 2a+1 (low half). With org=0, address b is byte b.
- R5: Opcode 10 is a read. On the edge that samples the last address bit, dout_oe rises and dout is 0, which is the dummy bit. Each of the next word-width edges drives one data bit of the addressed word, MSB first.
- R6: Once the last bit of a word has gone out, the next edge drives the MSB of the word at the next address. The address wraps from the top of memory to zero.
- R7: Opcodes 00 and 11 leave the memory unchanged and keep dout_oe low.
- R8: dout_oe drops as soon as chip select goes low. An edge that samples chip select low aborts the command, so a write cut short changes nothing.
- R9: dout_oe stays low during the start, opcode, address and write-data phases.
- R10: While the serial clock is held still, dout and dout_oe keep their values. When the clock resumes, the stream continues with the next bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| din | input | 1 | Serial command, address and write data |
| org | input | 1 | Word size: 1 = 16-bit, 0 = 8-bit |
| dout | output | 1 | Serial read data, zero while disabled |
| dout_oe | output | 1 | Output enable for dout |

## Verification
The checks assume three things about the inputs. Reset is applied once, before the first command. The org pin holds still while chip select is high. Both din and cs settle away from the rising serial-clock edge. The bench keeps to all three. It changes din, cs and org only on the falling edge of a free-running reference clock. It sets org in the same step that raises chip select. It stops the gated serial clock only while that clock is low, so a stall never makes a short pulse.

// File: rtl/tw_mem_pkg.sv
package tw_mem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_WDATA,
        ST_READ,
        ST_SKIP
    } tw_state_e;

    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;

endpackage

// File: rtl/tw_mem_ctrl.sv
module tw_mem_ctrl
    import tw_mem_pkg::*;
#(
    parameter int ABITS_W16 = 6,
    parameter int WORD_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs,
    input  logic                 din,
    input  logic                 org,
    output tw_state_e            state_o,
    output logic                 ld_first,
    output logic                 ld_next,
    output logic                 shift_en,
    output logic                 we,
    output logic [ABITS_W16:0]   rd_addr,
    output logic [ABITS_W16:0]   wr_addr,
    output logic [WORD_W-1:0]    wr_data
);
    localparam int AB8     = ABITS_W16 + 1;
    localparam int CNT_MAX = (WORD_W > AB8) ? WORD_W : AB8;
    localparam int CW      = $clog2(CNT_MAX + 1);

    tw_state_e         state_q, state_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic [AB8-1:0]    addr_q, addr_d;
    logic [1:0]        opc_q, opc_d;
    logic [WORD_W-2:0] wsh_q, wsh_d;

    logic [CW-1:0]     aw_last, ww_last;
    logic [AB8-1:0]    addr_shift, addr_inc;

    assign aw_last    = org ? CW'(ABITS_W16 - 1) : CW'(AB8 - 1);
    assign ww_last    = org ? CW'(WORD_W - 1) : CW'(WORD_W / 2 - 1);
    assign addr_shift = {addr_q[AB8-2:0], din};

    always_comb begin
        addr_inc = addr_q + 1'b1;
        if (org) begin
            addr_inc[AB8-1] = 1'b0;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        addr_d  = addr_q;
        opc_d   = opc_q;
        wsh_d   = wsh_q;
        if (!cs) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (din) begin
                        state_d = ST_OPC;
                        cnt_d   = '0;
                    end
                end
                ST_OPC: begin
                    opc_d = {opc_q[0], din};
                    if (cnt_q == CW'(1)) begin
                        state_d = ST_ADDR;
                        cnt_d   = '0;
                        addr_d  = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_ADDR: begin
                    addr_d = addr_shift;
                    if (cnt_q == aw_last) begin
                        cnt_d = '0;
                        if (opc_q == OPC_READ) begin
                            state_d = ST_READ;
                        end else if (opc_q == OPC_WRITE) begin
                            state_d = ST_WDATA;
                        end else begin
                            state_d = ST_SKIP;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_WDATA: begin
                    wsh_d = {wsh_q[WORD_W-3:0], din};
                    if (cnt_q == ww_last) begin
                        state_d = ST_SKIP;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_READ: begin
                    if (cnt_q == ww_last) begin
                        cnt_d  = '0;
                        addr_d = addr_inc;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_SKIP: begin
                    state_d = ST_SKIP;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            opc_q   <= '0;
            wsh_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            addr_q  <= addr_d;
            opc_q   <= opc_d;
            wsh_q   <= wsh_d;
        end
    end

    // outputs
    always_comb begin
        ld_first = cs && (state_q == ST_ADDR) && (cnt_q == aw_last) && (opc_q == OPC_READ);
        ld_next  = cs && (state_q == ST_READ) && (cnt_q == ww_last);
        shift_en = cs && (state_q == ST_READ);
        we       = cs && (state_q == ST_WDATA) && (cnt_q == ww_last);
        rd_addr  = ld_first ? addr_shift : addr_inc;
        wr_addr  = addr_q;
        wr_data  = {wsh_q, din};
        state_o  = state_q;
    end

endmodule

// File: rtl/tw_mem_array.sv
module tw_mem_array #(
    parameter int ABITS_W16 = 6,
    parameter int WORD_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               org,
    input  logic               we,
    input  logic [ABITS_W16:0] wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [ABITS_W16:0] rd_addr,
    output logic [WORD_W-1:0]  rd_word
);
    localparam int AB8   = ABITS_W16 + 1;
    localparam int BW    = WORD_W / 2;
    localparam int DEPTH = 1 << AB8;

    logic [BW-1:0] mem_q [DEPTH];

    logic [AB8-1:0] wr_hi, wr_lo, rd_hi, rd_lo;

    assign wr_hi = {wr_addr[AB8-2:0], 1'b0};
    assign wr_lo = {wr_addr[AB8-2:0], 1'b1};
    assign rd_hi = {rd_addr[AB8-2:0], 1'b0};
    assign rd_lo = {rd_addr[AB8-2:0], 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            if (org) begin
                mem_q[wr_hi] <= wr_data[WORD_W-1:BW];
                mem_q[wr_lo] <= wr_data[BW-1:0];
            end else begin
                mem_q[wr_addr] <= wr_data[BW-1:0];
            end
        end
    end

    // byte words are left-aligned so the shifter always emits from the top bit
    always_comb begin
        if (org) begin
            rd_word = {mem_q[rd_hi], mem_q[rd_lo]};
        end else begin
            rd_word = {mem_q[rd_addr], {BW{1'b0}}};
        end
    end

endmodule

// File: rtl/tw_mem_outsr.sv
module tw_mem_outsr #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic              shift,
    input  logic              reload,
    input  logic [WORD_W-1:0] word,
    output logic              bit_q,
    output logic              oe_q
);
    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            bit_q <= 1'b0;
            oe_q  <= 1'b0;
        end else if (clr) begin
            sh_q  <= '0;
            bit_q <= 1'b0;
            oe_q  <= 1'b0;
        end else if (load) begin
            sh_q  <= word;
            bit_q <= 1'b0;
            oe_q  <= 1'b1;
        end else if (shift) begin
            bit_q <= sh_q[WORD_W-1];
            sh_q  <= reload ? word : {sh_q[WORD_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
    import tw_mem_pkg::*;
#(
    parameter int ABITS_W16 = 6,
    parameter int WORD_W    = 16
) (
    input  logic sclk,
    input  logic rst_n,
    input  logic cs,
    input  logic din,
    input  logic org,
    output logic dout,
    output logic dout_oe
);
    localparam int AB8 = ABITS_W16 + 1;

    tw_state_e         ctl_state;
    logic              ld_first, ld_next, shift_en, wr_en;
    logic [AB8-1:0]    rd_addr, wr_addr;
    logic [WORD_W-1:0] wr_data, rd_word;
    logic              sr_bit, sr_oe;

    tw_mem_ctrl #(.ABITS_W16(ABITS_W16), .WORD_W(WORD_W)) u_ctrl (
        .clk      (sclk),
        .rst_n    (rst_n),
        .cs       (cs),
        .din      (din),
        .org      (org),
        .state_o  (ctl_state),
        .ld_first (ld_first),
        .ld_next  (ld_next),
        .shift_en (shift_en),
        .we       (wr_en),
        .rd_addr  (rd_addr),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    tw_mem_array #(.ABITS_W16(ABITS_W16), .WORD_W(WORD_W)) u_array (
        .clk     (sclk),
        .rst_n   (rst_n),
        .org     (org),
        .we      (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    tw_mem_outsr #(.WORD_W(WORD_W)) u_outsr (
        .clk    (sclk),
        .rst_n  (rst_n),
        .clr    (!cs),
        .load   (ld_first),
        .shift  (shift_en),
        .reload (ld_next),
        .word   (rd_word),
        .bit_q  (sr_bit),
        .oe_q   (sr_oe)
    );

    assign dout_oe = sr_oe & cs;
    assign dout    = dout_oe & sr_bit;

endmodule

// File: rtl/tw_mem_chk.sv
module tw_mem_chk
    import tw_mem_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs,
    input logic      din,
    input tw_state_e state,
    input logic      oe_q,
    input logic      bit_q,
    input logic      we
);

    // R2: a zero seen while idle keeps the decoder idle
    a_r2_zero_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cs && !din) |=> (state == ST_IDLE));

    // R4: a write commit never coincides with an active stream
    a_r4_write_not_streaming: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !oe_q);

    // R5: the first driven bit of a read is the dummy zero
    a_r5_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> !bit_q);

    // R5: the output turns on only out of the address phase
    a_r5_enable_from_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> ($past(state) == ST_ADDR));

    // R7: discarded commands neither write nor drive
    a_r7_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!oe_q && !we));

    // R8: a sampled low chip select turns the driver off
    a_r8_cs_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !oe_q);

    // R9: no drive during command phases
    a_r9_quiet_in_command: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_OPC || state == ST_ADDR || state == ST_WDATA) |-> !oe_q);

endmodule

bind tw_mem_slave tw_mem_chk u_chk (
    .clk   (sclk),
    .rst_n (rst_n),
    .cs    (cs),
    .din   (din),
    .state (ctl_state),
    .oe_q  (sr_oe),
    .bit_q (sr_bit),
    .we    (wr_en)
);

// File: tb/tw_mem_slave_bench.sv
module tw_mem_slave_bench;

    localparam int NBYTES = 128;

    logic fclk   = 1'b0;
    logic clk_en = 1'b1;
    logic sclk;
    logic rst_n  = 1'b0;
    logic cs     = 1'b0;
    logic din    = 1'b0;
    logic org    = 1'b1;
    logic dout, dout_oe;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    bit   watch  = 1'b0;
    bit   oe_seen = 1'b0;
    logic [7:0] mdl [NBYTES];

    always #10 fclk = ~fclk;
    assign sclk = fclk & clk_en;

    tw_mem_slave u_tw_mem_slave (
        .sclk    (sclk),
        .rst_n   (rst_n),
        .cs      (cs),
        .din     (din),
        .org     (org),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int awid(logic o);
        return o ? 6 : 7;
    endfunction

    function automatic int wwid(logic o);
        return o ? 16 : 8;
    endfunction

    function automatic logic [15:0] exp_word(logic o, int a);
        if (o) return {mdl[2*a], mdl[2*a+1]};
        return {8'h00, mdl[a]};
    endfunction

    task automatic send_bit(logic b);
        @(negedge fclk);
        if (watch && dout_oe) oe_seen = 1'b1;
        din = b;
    endtask

    task automatic send_bits(logic [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic begin_cmd(logic o);
        @(negedge fclk);
        org = o;
        cs  = 1'b1;
    endtask

    task automatic end_cmd();
        @(negedge fclk);
        cs  = 1'b0;
        din = 1'b0;
        @(negedge fclk);
    endtask

    task automatic do_write(logic o, int a, logic [15:0] d, int extra);
        begin_cmd(o);
        watch = 1'b1;
        oe_seen = 1'b0;
        send_bits(32'b101, 3);
        send_bits(a, awid(o));
        send_bits(d, wwid(o));
        for (int i = 0; i < extra; i++) send_bit(i[0]);
        watch = 1'b0;
        end_cmd();
        chk("R9", oe_seen, 0, "enable during write frame");
        if (o) begin
            mdl[2*a]   = d[15:8];
            mdl[2*a+1] = d[7:0];
        end else begin
            mdl[a] = d[7:0];
        end
    endtask

    task automatic do_read(logic o, int a, int nw, int lead, int stall_at);
        int   w;
        int   n;
        logic [15:0] got;
        logic oe_ok;
        logic held;
        w = wwid(o);
        n = o ? 64 : 128;
        begin_cmd(o);
        send_bits(0, lead);
        send_bits(32'b110, 3);
        send_bits(a, awid(o));
        @(negedge fclk);
        chk("R5", {dout_oe, dout}, 2'b10, "dummy bit");
        oe_ok = 1'b1;
        for (int k = 0; k < nw; k++) begin
            got = '0;
            for (int j = 0; j < w; j++) begin
                @(negedge fclk);
                if (stall_at == k * w + j) begin
                    held = dout;
                    clk_en = 1'b0;
                    repeat (40) @(negedge fclk);
                    chk("R10", {dout_oe, dout}, {1'b1, held}, "output during stall");
                    clk_en = 1'b1;
                end
                got = {got[14:0], dout};
                if (!dout_oe) oe_ok = 1'b0;
            end
            chk((k == 0) ? "R5" : "R6", got, exp_word(o, (a + k) % n), "stream word");
        end
        chk("R5", oe_ok, 1'b1, "enable held through stream");
        end_cmd();
        chk("R8", dout_oe, 0, "enable after deselect");
    endtask

    initial begin
        for (int i = 0; i < NBYTES; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge fclk);
        chk("R1", {dout_oe, dout}, 2'b00, "outputs in reset");
        rst_n = 1'b1;
        @(negedge fclk);
        chk("R1", {dout_oe, dout}, 2'b00, "outputs after reset");

        // R1: cleared contents
        do_read(1'b1, 0, 3, 0, -1);

        // R3 R4 R6: fill every 16-bit word, then stream all of it past the wrap
        for (int a = 0; a < 64; a++) begin
            logic [15:0] d;
            d = 16'(a * 16'h1357) ^ 16'hA5C3;
            do_write(1'b1, a, d, 0);
        end
        do_read(1'b1, 0, 66, 0, -1);
        do_read(1'b1, 62, 4, 0, -1);

        // R4: byte writes, then mixed-organization readback
        do_write(1'b0, 0, 16'h003C, 0);
        do_write(1'b0, 1, 16'h00D2, 0);
        do_write(1'b0, 127, 16'h0081, 3);
        do_write(1'b0, 64, 16'h0077, 0);
        do_read(1'b1, 0, 1, 0, -1);
        do_read(1'b0, 120, 140, 0, -1);

        // R2: leading zeros before the start bit
        do_read(1'b1, 17, 2, 4, -1);
        do_read(1'b0, 9, 2, 1, -1);

        // R7: opcodes 00 and 11 do nothing
        begin_cmd(1'b1);
        watch = 1'b1; oe_seen = 1'b0;
        send_bits(32'b100, 3); send_bits(5, 6); send_bits(32'hFFFF, 16);
        watch = 1'b0; end_cmd();
        chk("R7", oe_seen, 0, "enable with opcode 00");
        begin_cmd(1'b1);
        watch = 1'b1; oe_seen = 1'b0;
        send_bits(32'b111, 3); send_bits(5, 6); send_bits(32'h0000, 16);
        watch = 1'b0; end_cmd();
        chk("R7", oe_seen, 0, "enable with opcode 11");
        do_read(1'b1, 5, 1, 0, -1);

        // R8: write aborted mid-word leaves memory alone
        begin_cmd(1'b1);
        send_bits(32'b101, 3); send_bits(9, 6); send_bits(32'h3FF, 10);
        end_cmd();
        do_read(1'b1, 9, 1, 0, -1);

        // R8: deselect during a stream drops the enable at once
        begin_cmd(1'b1);
        send_bits(32'b110, 3); send_bits(20, 6);
        repeat (5) @(negedge fclk);
        chk("R8", dout_oe, 1, "enable mid-stream");
        cs = 1'b0;
        #1;
        chk("R8", dout_oe, 0, "enable right after deselect");
        @(negedge fclk);
        @(negedge fclk);

        // R10: clock held in the middle of a word
        do_read(1'b1, 33, 2, 0, 7);
        do_read(1'b0, 64, 2, 0, 12);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge fclk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule